// File: doc/BRIEF.md
# Tag-Checked Programmable Functional Unit

This execute-stage unit serves a custom "run programmable function" instruction. Each dispatch names a function identifier. The unit compares that identifier with the tag of the configuration now held in the unit. On a hit it combines two operands, which come straight from the register file, and returns the result in the same cycle. The operation it applies is picked by the loaded function-select code. On a miss it produces no result. Instead it raises a fault and reports the identifier it was asked for, so that a trap handler can install the right configuration and retry.

The only state in the unit is the loaded configuration: a valid flag, an 11-bit tag and a 3-bit select code. No operand or result is ever stored, so a context switch needs nothing saved. A configuration write port installs a new tag and select code, and they take effect from the following cycle. The small set of combinational functions stands in for a reconfigurable array.

Top module: `pfu_dispatch`

## Requirements
- R1: After reset no configuration is valid, so any dispatch with any identifier faults until a configuration has been written.
- R2: When `issue_valid` is high and `issue_fid` equals the loaded tag, `res_valid` and `rf_we` are high in that same cycle, `rf_waddr` equals `dst_idx`, and `fault` is low.
- R3: When `issue_valid` is high and the identifier misses, `fault` is high, `fault_fid` equals `issue_fid`, and `res_valid`, `rf_we` and `res_data` are all zero.
- R4: When `issue_valid` is low, `res_valid`, `rf_we` and `fault` are all low, whatever the configuration holds.
- R5: The select codes for the bitwise and add group are 0, 1, 2 and 3. They give A AND B, A OR B, A XOR B and A+B modulo 2^DATA_W, in that order.
- R6: Select code 4 gives the count of set bits in A, zero-extended. Select code 6 gives the count of set bits in A XOR B. Operand B has no effect under code 4.
- R7: Select code 5 gives A AND NOT B. Select code 7 gives A-B modulo 2^DATA_W.
- R8: A configuration write in the same cycle as a dispatch does not affect that dispatch. The new tag and select code apply from the next cycle onward.
- R9: The tag compare uses all 11 identifier bits. Identifiers 0 and 2047 are both usable, and a difference in any single bit, including bit 10, causes a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_tag | input | 11 | Function identifier to install |
| cfg_sel | input | 3 | Function-select code to install |
| issue_valid | input | 1 | A custom instruction is dispatched this cycle |
| issue_fid | input | 11 | Requested function identifier |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| dst_idx | input | 5 | Destination register index |
| res_valid | output | 1 | Result is valid this cycle |
| res_data | output | 32 | Result value, zero when not valid |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 5 | Register file write index |
| fault | output | 1 | Configuration miss, trap requested |
| fault_fid | output | 11 | Identifier that missed |

## Verification
Some properties are checked on every cycle. A result and a fault are never raised together. A fault never comes with a register write or non-zero data. An idle cycle is quiet. The write index follows the destination index. The configuration changes only on a write, and a write is taken on the next edge, while the unit stays unconfigured until the first write. Only the bench scenarios can show the arithmetic itself: the values for each select code, including wrap-around and the popcount extremes. The bench also shows that a write alongside a dispatch leaves that dispatch with the old configuration, and that the extreme tags compare correctly on all bits.

// File: rtl/pfu_pkg.sv
package pfu_pkg;

    // Function-select codes understood by the function core.
    typedef enum logic [2:0] {
        FN_AND  = 3'd0,
        FN_OR   = 3'd1,
        FN_XOR  = 3'd2,
        FN_ADD  = 3'd3,
        FN_POPA = 3'd4,
        FN_ANDN = 3'd5,
        FN_HAMM = 3'd6,
        FN_SUB  = 3'd7
    } fn_e;

    localparam int unsigned FN_SEL_W = $bits(fn_e);

endpackage

// File: rtl/pfu_cfg_store.sv
module pfu_cfg_store #(
    parameter int unsigned FID_W = 11,
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [FID_W-1:0] wr_tag,
    input  logic [SEL_W-1:0] wr_sel,
    output logic             cfg_valid,
    output logic [FID_W-1:0] cfg_tag,
    output logic [SEL_W-1:0] cfg_sel
);

    typedef struct packed {
        logic             valid;
        logic [FID_W-1:0] tag;
        logic [SEL_W-1:0] sel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.valid = 1'b1;
            cfg_d.tag   = wr_tag;
            cfg_d.sel   = wr_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_valid = cfg_q.valid;
    assign cfg_tag   = cfg_q.tag;
    assign cfg_sel   = cfg_q.sel;

    // R1: without a write the unit stays unconfigured
    p_cold_until_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.valid && !wr_en) |=> !cfg_q.valid);

    // R8: a write is taken on the next edge
    p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg_q.valid && cfg_q.tag == $past(wr_tag) && cfg_q.sel == $past(wr_sel)));

    // R8: without a write the configuration holds
    p_hold_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q));

endmodule

// File: rtl/pfu_tag_match.sv
module pfu_tag_match #(
    parameter int unsigned FID_W = 11
) (
    input  logic             req_valid,
    input  logic [FID_W-1:0] req_fid,
    input  logic             cfg_valid,
    input  logic [FID_W-1:0] cfg_tag,
    output logic             hit,
    output logic             miss
);

    logic [FID_W-1:0] bit_eq;
    logic             all_eq;

    for (genvar g = 0; g < FID_W; g++) begin : g_bit
        assign bit_eq[g] = ~(req_fid[g] ^ cfg_tag[g]);
    end

    always_comb begin
        all_eq = &bit_eq;
        hit    = req_valid & cfg_valid & all_eq;
        miss   = req_valid & ~(cfg_valid & all_eq);
    end

endmodule

// File: rtl/pfu_func_core.sv
module pfu_func_core
    import pfu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  fn_e               sel,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] y
);

    localparam int unsigned CNT_W = $clog2(DATA_W + 1);

    function automatic logic [CNT_W-1:0] ones(input logic [DATA_W-1:0] v);
        logic [CNT_W-1:0] c;
        c = '0;
        for (int i = 0; i < DATA_W; i++) begin
            c = c + CNT_W'(v[i]);
        end
        return c;
    endfunction

    always_comb begin
        unique case (sel)
            FN_AND:  y = opa & opb;
            FN_OR:   y = opa | opb;
            FN_XOR:  y = opa ^ opb;
            FN_ADD:  y = opa + opb;
            FN_POPA: y = DATA_W'(ones(opa));
            FN_ANDN: y = opa & ~opb;
            FN_HAMM: y = DATA_W'(ones(opa ^ opb));
            FN_SUB:  y = opa - opb;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/pfu_dispatch.sv
module pfu_dispatch
    import pfu_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned FID_W  = 11,
    parameter int unsigned REG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [FID_W-1:0]  cfg_tag,
    input  logic [2:0]        cfg_sel,
    input  logic              issue_valid,
    input  logic [FID_W-1:0]  issue_fid,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [REG_W-1:0]  dst_idx,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_waddr,
    output logic              fault,
    output logic [FID_W-1:0]  fault_fid
);

    localparam int unsigned SEL_W = FN_SEL_W;

    logic             ld_valid;
    logic [FID_W-1:0] ld_tag;
    logic [SEL_W-1:0] ld_sel;
    logic             hit, miss;
    logic [DATA_W-1:0] fn_y;

    pfu_cfg_store #(.FID_W(FID_W), .SEL_W(SEL_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_tag    (cfg_tag),
        .wr_sel    (cfg_sel),
        .cfg_valid (ld_valid),
        .cfg_tag   (ld_tag),
        .cfg_sel   (ld_sel)
    );

    pfu_tag_match #(.FID_W(FID_W)) u_match (
        .req_valid (issue_valid),
        .req_fid   (issue_fid),
        .cfg_valid (ld_valid),
        .cfg_tag   (ld_tag),
        .hit       (hit),
        .miss      (miss)
    );

    pfu_func_core #(.DATA_W(DATA_W)) u_core (
        .sel (fn_e'(ld_sel)),
        .opa (src_a),
        .opb (src_b),
        .y   (fn_y)
    );

    always_comb begin
        res_valid = hit;
        rf_we     = hit;
        res_data  = hit  ? fn_y      : '0;
        rf_waddr  = hit  ? dst_idx   : '0;
        fault     = miss;
        fault_fid = miss ? issue_fid : '0;
    end

    // R3: result and trap are mutually exclusive
    p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && fault));

    // R3: a trap never writes the register file
    p_fault_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!rf_we && res_data == '0));

    // R4: no dispatch, no activity
    p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> (!res_valid && !fault && !rf_we));

    // R2: write index follows the destination
    p_waddr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_waddr == dst_idx && res_valid));

endmodule

// File: tb/pfu_dispatch_test.sv
module pfu_dispatch_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [10:0] cfg_tag = '0;
    logic [2:0]  cfg_sel = '0;
    logic        issue_valid = 1'b0;
    logic [10:0] issue_fid = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [4:0]  dst_idx = '0;
    logic        res_valid;
    logic [31:0] res_data;
    logic        rf_we;
    logic [4:0]  rf_waddr;
    logic        fault;
    logic [10:0] fault_fid;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pfu_dispatch uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tag(cfg_tag), .cfg_sel(cfg_sel),
        .issue_valid(issue_valid), .issue_fid(issue_fid), .src_a(src_a), .src_b(src_b),
        .dst_idx(dst_idx), .res_valid(res_valid), .res_data(res_data), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .fault(fault), .fault_fid(fault_fid)
    );

    // {tag[10:0], sel[2:0], a[31:0], b[31:0], expected[31:0]}
    localparam logic [109:0] VEC [0:9] = '{
        {11'h000, 3'd0, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'h00F0_000F},
        {11'h7FF, 3'd1, 32'hF000_0000, 32'h0000_000F, 32'hF000_000F},
        {11'h001, 3'd2, 32'hFFFF_0000, 32'h0F0F_0F0F, 32'hF0F0_0F0F},
        {11'h400, 3'd3, 32'hFFFF_FFFF, 32'h0000_0002, 32'h0000_0001},
        {11'h2AA, 3'd4, 32'h8000_0001, 32'hFFFF_FFFF, 32'h0000_0002},
        {11'h555, 3'd4, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0020},
        {11'h123, 3'd5, 32'hFF00_FF00, 32'h0F0F_0F0F, 32'hF000_F000},
        {11'h3FF, 3'd6, 32'h0000_00FF, 32'h0000_0F0F, 32'h0000_0008},
        {11'h456, 3'd7, 32'h0000_0005, 32'h0000_0007, 32'hFFFF_FFFE},
        {11'h7FE, 3'd3, 32'h1234_5678, 32'h1111_1111, 32'h2345_6789}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_cfg(input logic [10:0] t, input logic [2:0] s);
        @(negedge clk);
        issue_valid = 1'b0;
        cfg_we = 1'b1; cfg_tag = t; cfg_sel = s;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic issue(input logic [10:0] f, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] d);
        issue_valid = 1'b1; issue_fid = f; src_a = a; src_b = b; dst_idx = d;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: idle after reset
        #1;
        chk("R4 idle res_valid", 32'(res_valid), 32'd0);
        chk("R4 idle fault", 32'(fault), 32'd0);

        // R1: unconfigured unit faults on any identifier
        issue(11'h000, 32'h1, 32'h2, 5'd3);
        chk("R1 cold fault", 32'(fault), 32'd1);
        chk("R1 cold res_valid", 32'(res_valid), 32'd0);
        @(negedge clk);
        issue(11'h7FF, 32'h1, 32'h2, 5'd3);
        chk("R1 cold fault 7FF", 32'(fault), 32'd1);

        // Table walk: R2, R5, R6, R7, R9
        for (int i = 0; i < 10; i++) begin
            load_cfg(VEC[i][109:99], VEC[i][98:96]);
            issue(VEC[i][109:99], VEC[i][95:64], VEC[i][63:32], 5'(i + 1));
            case (VEC[i][98:96])
                3'd4, 3'd6: chk("R6 popcount value", res_data, VEC[i][31:0]);
                3'd5, 3'd7: chk("R7 andn/sub value", res_data, VEC[i][31:0]);
                default:    chk("R5 logic/add value", res_data, VEC[i][31:0]);
            endcase
            chk("R2 res_valid", 32'(res_valid), 32'd1);
            chk("R2 rf_we", 32'(rf_we), 32'd1);
            chk("R2 rf_waddr", 32'(rf_waddr), 32'(i + 1));
            chk("R9 no fault on own tag", 32'(fault), 32'd0);
        end

        // R6: operand B ignored under code 4
        load_cfg(11'h010, 3'd4);
        issue(11'h010, 32'h0000_000F, 32'h0000_0000, 5'd1);
        chk("R6 popa b=0", res_data, 32'd4);
        issue(11'h010, 32'h0000_000F, 32'hFFFF_FFFF, 5'd1);
        chk("R6 popa b=ones", res_data, 32'd4);

        // R3 / R9: single-bit mismatches
        load_cfg(11'h155, 3'd3);
        issue(11'h154, 32'h5, 32'h6, 5'd9);
        chk("R3 fault low bit", 32'(fault), 32'd1);
        chk("R3 fault_fid", 32'(fault_fid), 32'h154);
        chk("R3 rf_we low", 32'(rf_we), 32'd0);
        chk("R3 res_valid low", 32'(res_valid), 32'd0);
        chk("R3 res_data zero", res_data, 32'd0);
        issue(11'h555, 32'h5, 32'h6, 5'd9);
        chk("R9 bit10 mismatch fault", 32'(fault), 32'd1);
        chk("R9 bit10 fault_fid", 32'(fault_fid), 32'h555);

        // R4: matching config but no dispatch
        issue_valid = 1'b0; #1;
        chk("R4 no issue res_valid", 32'(res_valid), 32'd0);
        chk("R4 no issue rf_we", 32'(rf_we), 32'd0);
        chk("R4 no issue fault", 32'(fault), 32'd0);

        // R8: write alongside a dispatch
        load_cfg(11'h0AA, 3'd3);
        cfg_we = 1'b1; cfg_tag = 11'h0BB; cfg_sel = 3'd2;
        issue(11'h0AA, 32'd6, 32'd3, 5'd7);
        chk("R8 same-cycle uses old sel", res_data, 32'd9);
        chk("R8 same-cycle no fault", 32'(fault), 32'd0);
        @(negedge clk);
        cfg_we = 1'b0;
        issue(11'h0AA, 32'd6, 32'd3, 5'd7);
        chk("R8 old tag now faults", 32'(fault), 32'd1);
        issue(11'h0BB, 32'd6, 32'd3, 5'd7);
        chk("R8 new sel applied", res_data, 32'd5);
        chk("R8 new tag hit", 32'(res_valid), 32'd1);

        @(negedge clk);
        issue_valid = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule